// File: doc/BRIEF.md
# Banked Multi-Depth Palette Lookup

This block turns raw pixel values fetched from display memory into 4-bit red, green and blue channel values for an LCD panel. The pixel depth can be 1, 2, 4 or 8 bits, and the block runs in either monochrome or colour mode. In monochrome mode only the green table drives the output, and the red and blue channels stay at zero. Shallow depths do not use a whole 16-entry table. Instead they index one bank inside it, and the bank is picked by a 2-bit bank field. A separate bank field exists for each mode.

Each channel has its own 16 x 4 table. A host write port loads one entry of one table per clock. Pixels come in with a valid strobe. One clock later the table data is read out of synchronous RAM. On the next clock the final channel values are registered together with an output valid strobe. When the display-enable input is low, every channel output is forced to zero.

Top module: `pal_lookup`

## Requirements
- R1: At depth code 0 (1 bit per pixel) no table is used. Pixel bit 0 = 1 gives green 4'hF and bit 0 = 0 gives green 4'h0. Red and blue are 0 whatever the colour mode.
- R2: At depth code 1 (2 bits per pixel) in monochrome mode (`color_mode` = 0), the green table index is {`mono_bank`, pixel[1:0]}. `color_bank` has no effect on it.
- R3: At depth code 1 in colour mode, all three table indices are {`color_bank`, pixel[1:0]}.
- R4: At depth code 2 (4 bits per pixel), pixel[3:0] indexes all 16 entries of every table in use, and both bank fields are ignored.
- R5: At depth code 3 (8 bits per pixel), the red index is {`color_bank`[0], pixel[7:5]} and the green index is {`color_bank`[0], pixel[4:2]}. The blue index is {`color_bank`[1:0], pixel[1:0]}.
- R6: In monochrome mode `out_red` and `out_blue` are 0 at every depth.
- R7: When `disp_on` is 0 for a valid pixel, all three channel outputs for that pixel are 0.
- R8: A pixel accepted with `pix_valid` at clock edge k gives `out_valid` = 1 and its channel values after edge k+2. `out_valid` is 0 after edge k+2 when no pixel was accepted at edge k.
- R9: When no valid pixel reaches the output stage, the channel outputs keep their previous values.
- R10: A host write with `tbl_we` = 1 loads `tbl_wdata` into entry `tbl_addr` of the table chosen by `tbl_sel` (0 red, 1 green, 2 blue, 3 none). It changes no other table. A lookup of the same entry in the same cycle returns the old value, and later lookups return the new one.
- R11: After reset `out_valid` is 0 and all channel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel present on `pix_data` |
| pix_data | input | 8 | Raw pixel value, right-aligned |
| depth | input | 2 | Depth code: 0=1, 1=2, 2=4, 3=8 bits per pixel |
| color_mode | input | 1 | 1 = colour, 0 = monochrome |
| mono_bank | input | 2 | Bank field for monochrome 2-bit pixels |
| color_bank | input | 2 | Bank field for colour 2-bit and 8-bit pixels |
| disp_on | input | 1 | 0 forces channel outputs to zero |
| tbl_we | input | 1 | Host table write enable |
| tbl_sel | input | 2 | Table select: 0 red, 1 green, 2 blue, 3 none |
| tbl_addr | input | 4 | Table entry to write |
| tbl_wdata | input | 4 | Entry value |
| out_valid | output | 1 | Channel outputs hold a new pixel |
| out_red | output | 4 | Red channel value |
| out_green | output | 4 | Green (or monochrome) channel value |
| out_blue | output | 4 | Blue channel value |

## Verification
A host write and a pixel lookup can land on the same table entry in the same cycle. To provoke this, the bench drives `tbl_we` for green entry 3 in the same cycle as a valid 4-bit monochrome pixel of value 3. The result passes if that pixel still shows the old entry value and the next identical pixel shows the new value. A write to the red table is then checked to leave the green output of the same index unchanged.

// File: rtl/pal_lookup_pkg.sv
package pal_lookup_pkg;
  localparam int CH_W    = 4;            // channel output width
  localparam int IDX_W   = 4;            // table index width
  localparam int PIX_W   = 8;            // raw pixel width
  localparam int NCH     = 3;            // number of colour tables
  localparam int SEL_W   = 2;            // host table select width
  localparam int ENTRIES = 1 << IDX_W;

  localparam int CH_RED   = 0;
  localparam int CH_GREEN = 1;
  localparam int CH_BLUE  = 2;

  typedef enum logic [1:0] {
    DEPTH_1 = 2'd0,
    DEPTH_2 = 2'd1,
    DEPTH_4 = 2'd2,
    DEPTH_8 = 2'd3
  } depth_e;
endpackage

// File: rtl/pal_index_gen.sv
module pal_index_gen
  import pal_lookup_pkg::*;
(
  input  logic [PIX_W-1:0] pix,
  input  depth_e           depth,
  input  logic             color_mode,
  input  logic [1:0]       mono_bank,
  input  logic [1:0]       color_bank,
  output logic [IDX_W-1:0] idx_red,
  output logic [IDX_W-1:0] idx_green,
  output logic [IDX_W-1:0] idx_blue
);
  logic [1:0] bank2;

  always_comb begin
    bank2 = color_mode ? color_bank : mono_bank;
    unique case (depth)
      DEPTH_2: begin
        idx_red   = {color_bank, pix[1:0]};
        idx_green = {bank2, pix[1:0]};
        idx_blue  = {color_bank, pix[1:0]};
      end
      DEPTH_4: begin
        idx_red   = pix[3:0];
        idx_green = pix[3:0];
        idx_blue  = pix[3:0];
      end
      DEPTH_8: begin
        idx_red   = {color_bank[0], pix[7:5]};
        idx_green = {color_bank[0], pix[4:2]};
        idx_blue  = {color_bank, pix[1:0]};
      end
      default: begin
        idx_red   = '0;
        idx_green = '0;
        idx_blue  = '0;
      end
    endcase
  end

  always_comb begin
    if (depth == DEPTH_4)
      assert (idx_green == pix[3:0] && idx_red == idx_blue);
  end
endmodule

// File: rtl/pal_table_ram.sv
module pal_table_ram #(
  parameter int W     = 4,
  parameter int AW    = 4,
  parameter int SEL_W = 2,
  parameter int CH_ID = 0
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [AW-1:0]    raddr,
  output logic [W-1:0]     rdata
);
  localparam int DEPTH = 1 << AW;
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(CH_ID);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && sel == MY_SEL)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage
  import pal_lookup_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            s_valid,
  input  depth_e          s_depth,
  input  logic            s_color,
  input  logic            s_disp,
  input  logic            s_pix0,
  input  logic [CH_W-1:0] rd_red,
  input  logic [CH_W-1:0] rd_green,
  input  logic [CH_W-1:0] rd_blue,
  output logic            o_valid,
  output logic [CH_W-1:0] o_red,
  output logic [CH_W-1:0] o_green,
  output logic [CH_W-1:0] o_blue
);
  logic [CH_W-1:0] n_red, n_green, n_blue;

  always_comb begin
    n_red   = '0;
    n_green = '0;
    n_blue  = '0;
    if (s_disp) begin
      if (s_depth == DEPTH_1) begin
        n_green = {CH_W{s_pix0}};
      end else begin
        n_green = rd_green;
        if (s_color) begin
          n_red  = rd_red;
          n_blue = rd_blue;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_red   <= '0;
      o_green <= '0;
      o_blue  <= '0;
    end else begin
      o_valid <= s_valid;
      if (s_valid) begin
        o_red   <= n_red;
        o_green <= n_green;
        o_blue  <= n_blue;
      end
    end
  end

  // R7
  disp_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !s_disp) |=> (o_red == '0 && o_green == '0 && o_blue == '0));

  // R6
  mono_rb_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !s_color) |=> (o_red == '0 && o_blue == '0));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !s_valid |=> ($stable(o_red) && $stable(o_green) && $stable(o_blue)));

  // R1
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_disp && s_depth == DEPTH_1) |=>
      (o_green == {CH_W{$past(s_pix0)}} && o_red == '0 && o_blue == '0));
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup
  import pal_lookup_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic [7:0]       pix_data,
  input  logic [1:0]       depth,
  input  logic             color_mode,
  input  logic [1:0]       mono_bank,
  input  logic [1:0]       color_bank,
  input  logic             disp_on,
  input  logic             tbl_we,
  input  logic [1:0]       tbl_sel,
  input  logic [3:0]       tbl_addr,
  input  logic [3:0]       tbl_wdata,
  output logic             out_valid,
  output logic [3:0]       out_red,
  output logic [3:0]       out_green,
  output logic [3:0]       out_blue
);
  depth_e           depth_in;
  logic [IDX_W-1:0] idx [NCH];
  logic [CH_W-1:0]  rd  [NCH];

  assign depth_in = depth_e'(depth);

  pal_index_gen u_idx (
    .pix        (pix_data),
    .depth      (depth_in),
    .color_mode (color_mode),
    .mono_bank  (mono_bank),
    .color_bank (color_bank),
    .idx_red    (idx[CH_RED]),
    .idx_green  (idx[CH_GREEN]),
    .idx_blue   (idx[CH_BLUE])
  );

  for (genvar c = 0; c < NCH; c++) begin : g_tbl
    pal_table_ram #(
      .W     (CH_W),
      .AW    (IDX_W),
      .SEL_W (SEL_W),
      .CH_ID (c)
    ) u_ram (
      .clk   (clk),
      .we    (tbl_we),
      .sel   (tbl_sel),
      .waddr (tbl_addr),
      .wdata (tbl_wdata),
      .raddr (idx[c]),
      .rdata (rd[c])
    );
  end

  // control travelling alongside the table read
  logic   s_valid, s_color, s_disp, s_pix0;
  depth_e s_depth;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_color <= 1'b0;
      s_disp  <= 1'b0;
      s_pix0  <= 1'b0;
      s_depth <= DEPTH_1;
    end else begin
      s_valid <= pix_valid;
      s_color <= color_mode;
      s_disp  <= disp_on;
      s_pix0  <= pix_data[0];
      s_depth <= depth_in;
    end
  end

  pal_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .s_valid  (s_valid),
    .s_depth  (s_depth),
    .s_color  (s_color),
    .s_disp   (s_disp),
    .s_pix0   (s_pix0),
    .rd_red   (rd[CH_RED]),
    .rd_green (rd[CH_GREEN]),
    .rd_blue  (rd[CH_BLUE]),
    .o_valid  (out_valid),
    .o_red    (out_red),
    .o_green  (out_green),
    .o_blue   (out_blue)
  );

  // R8
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> ##1 out_valid);

  // R8
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> ##1 !out_valid);
endmodule

// File: tb/pal_lookup_bench.sv
module pal_lookup_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = '0;
  logic [1:0] depth = '0;
  logic       color_mode = 1'b0;
  logic [1:0] mono_bank = '0;
  logic [1:0] color_bank = '0;
  logic       disp_on = 1'b1;
  logic       tbl_we = 1'b0;
  logic [1:0] tbl_sel = 2'd3;
  logic [3:0] tbl_addr = '0;
  logic [3:0] tbl_wdata = '0;
  logic       out_valid;
  logic [3:0] out_red, out_green, out_blue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pal_lookup u_pal_lookup (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
    .depth(depth), .color_mode(color_mode), .mono_bank(mono_bank),
    .color_bank(color_bank), .disp_on(disp_on), .tbl_we(tbl_we),
    .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .out_valid(out_valid), .out_red(out_red), .out_green(out_green),
    .out_blue(out_blue)
  );

  // stimulus {depth, color, mono_bank, color_bank, disp, pix} + expected {r,g,b}
  // tables: red[i]=15-i, green[i]=(7i+3)%16, blue[i]=(11i+6)%16
  localparam int NV = 14;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 8'h01, 12'h0F0},  // R1 white
    {2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 8'hFE, 12'h000},  // R1 black
    {2'd0, 1'b1, 2'd0, 2'd0, 1'b1, 8'h01, 12'h0F0},  // R1 colour ignored
    {2'd1, 1'b0, 2'd2, 2'd1, 1'b1, 8'h02, 12'h090},  // R2 idx 10
    {2'd1, 1'b1, 2'd3, 2'd1, 1'b1, 8'hFD, 12'hA6D},  // R3 idx 5
    {2'd1, 1'b1, 2'd0, 2'd3, 1'b1, 8'h00, 12'h37A},  // R3 idx 12
    {2'd2, 1'b0, 2'd3, 2'd3, 1'b1, 8'h07, 12'h040},  // R4 mono idx 7
    {2'd2, 1'b1, 2'd2, 2'd1, 1'b1, 8'hAE, 12'h150},  // R4 colour idx 14
    {2'd3, 1'b1, 2'd0, 2'd0, 1'b1, 8'hAE, 12'hA8C},  // R5 r5 g3 b2
    {2'd3, 1'b1, 2'd0, 2'd1, 1'b1, 8'h59, 12'h55D},  // R5 r10 g14 b5
    {2'd3, 1'b1, 2'd0, 2'd2, 1'b1, 8'h59, 12'hDD9},  // R5 r2 g6 b9
    {2'd3, 1'b0, 2'd0, 2'd1, 1'b1, 8'h59, 12'h050},  // R6 mono 8-bit
    {2'd2, 1'b1, 2'd0, 2'd0, 1'b0, 8'h05, 12'h000},  // R7 display off
    {2'd1, 1'b0, 2'd0, 2'd3, 1'b1, 8'h01, 12'h0A0}   // R2 mono bank 0
  };

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0; tbl_sel = 2'd3;
  endtask

  task automatic set_pix(input logic [27:0] v);
    depth = v[27:26]; color_mode = v[25]; mono_bank = v[24:23];
    color_bank = v[22:21]; disp_on = v[20]; pix_data = v[19:12];
  endtask

  function automatic logic [12:0] outs();
    return {out_valid, out_red, out_green, out_blue};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", outs(), 13'h0000);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      host_wr(2'd0, 4'(i), 4'(15 - i));
      host_wr(2'd1, 4'(i), 4'((7 * i + 3) % 16));
      host_wr(2'd2, 4'(i), 4'((11 * i + 6) % 16));
    end
    chk("R11", outs(), 13'h0000);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_pix(VEC[i]); pix_valid = 1'b1;
      @(negedge clk);
      pix_valid = 1'b0;
      if (i == 0) chk("R8", {12'h000, out_valid}, 13'h0000);
      @(negedge clk);
      chk($sformatf("R1-R7 vector %0d", i), outs(), {1'b1, VEC[i][11:0]});
    end

    // R9: idle cycles with changing inputs keep the last outputs
    pix_data = 8'hFF; depth = 2'd2; color_mode = 1'b1; disp_on = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", outs(), {1'b0, 12'h0A0});

    // R8 back-to-back stream
    @(negedge clk);
    set_pix({2'd2, 1'b1, 2'd0, 2'd0, 1'b1, 8'h00, 12'h0}); pix_valid = 1'b1;
    @(negedge clk);
    set_pix({2'd2, 1'b1, 2'd0, 2'd0, 1'b1, 8'h01, 12'h0});
    @(negedge clk);
    chk("R8 stream 0", outs(), {1'b1, 12'hF36});
    set_pix({2'd2, 1'b1, 2'd0, 2'd0, 1'b1, 8'h0F, 12'h0});
    @(negedge clk);
    chk("R8 stream 1", outs(), {1'b1, 12'hEA1});
    pix_valid = 1'b0;
    @(negedge clk);
    chk("R8 stream 2", outs(), {1'b1, 12'h0CB});
    @(negedge clk);
    chk("R8 idle", {12'h000, out_valid}, 13'h0000);

    // R10 write/lookup collision on green entry 3 (old value 8)
    @(negedge clk);
    set_pix({2'd2, 1'b0, 2'd0, 2'd0, 1'b1, 8'h03, 12'h0}); pix_valid = 1'b1;
    tbl_we = 1'b1; tbl_sel = 2'd1; tbl_addr = 4'd3; tbl_wdata = 4'hE;
    @(negedge clk);
    tbl_we = 1'b0; tbl_sel = 2'd3;
    @(negedge clk);
    chk("R10 same-cycle old", outs(), {1'b1, 12'h080});
    @(negedge clk);
    chk("R10 next new", outs(), {1'b1, 12'h0E0});
    pix_valid = 1'b0;

    // R10 write to red leaves green index 7 alone
    host_wr(2'd0, 4'd7, 4'h9);
    host_wr(2'd3, 4'd7, 4'h1);
    @(negedge clk);
    set_pix({2'd2, 1'b1, 2'd0, 2'd0, 1'b1, 8'h07, 12'h0}); pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    chk("R10 isolation", outs(), {1'b1, 12'h943});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule